// File: doc/BRIEF.md
# Multichannel UART Interrupt Aggregator

This block collects the interrupt conditions of eight UART channels into one status view. Each channel keeps a pending latch for every event-type source. Each latch is cleared by the event that belongs to its source: a register read, the receive FIFO draining, or the arrival of the next character. A priority encoder in each channel reduces the pending sources to a 3-bit code, and the lowest nonzero code wins.

The eight codes are packed into a 24-bit status word that software reads as three bytes. A summary vector has one bit per channel, and a single interrupt line is the OR of the summary. Channel 0 also carries two device-wide sources, a pin-change event and a timer timeout. No other channel can report those two codes.

Every output is a combinational function of the latch state and the current receive levels. An event sampled at a clock edge therefore becomes visible in the cycle after that edge. A clearing read that is high at an edge takes effect in the cycle after that edge.

Top module: `uart_irq_aggregator`

## Requirements
- R1: After reset all latches are clear. With the receive levels at zero and the transmit-empty flags low, every code, the summary and `irq_o` are 0. The transmit edge detector resets as if the selected empty flag were already high.
- R2: Code 1 is reported while the channel's receive level is nonzero and at least its trigger level; this condition is not latched. Code 1 is also reported while the line-error latch is set. Any of the four `line_err_i` bits of the channel sets that latch, and `lsr_rd_i` clears it.
- R3: Code 2 is reported while the receive-timeout latch is set. `rx_tmo_i` sets the latch, and it clears at an edge where the channel's receive level is 0.
- R4: Code 3 is reported while the transmit-ready latch is set. The latch is set on a 0-to-1 transition of the selected empty flag, and `isr_rd_i` clears it. The selected flag is `tsr_empty_i` when `auto485_i` is 1, and `thr_empty_i` otherwise.
- R5: Code 4 is reported while any of three latches is set:
  - the modem latch, set by `modem_evt_i` and cleared by `msr_rd_i`;
  - the flow-control latch, set by `xon_evt_i` and cleared by `isr_rd_i`;
  - the special-character latch, set by `spc_evt_i` and cleared by either `isr_rd_i` or `rx_char_i`.
- R6: On channel 0 only, code 6 is reported for the pin latch and code 7 for the timer latch. `pin_evt_i` sets the pin latch and `pin_rd_i` clears it. `tmr_evt_i` sets the timer latch and `tmr_rd_i` clears it. No channel ever reports code 5, and channels 1 to 7 never report 6 or 7.
- R7: When several sources are pending, the lowest nonzero code is reported. Clearing that source exposes the next pending source in the same cycle that the clear takes effect.
- R8: A setting event in the same cycle as its clearing condition leaves the latch set.
- R9: Channel n's code is in `status_o[3n+2:3n]`, so byte k of the status view is `status_o[8k+7:8k]`. `summary_o[n]` is 1 exactly when channel n's code is nonzero, and `irq_o` is the OR of `summary_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_level_i | input | 56 | Receive FIFO fill per channel, 7 bits each |
| rx_trig_i | input | 56 | Receive trigger level per channel, 7 bits each |
| rx_tmo_i | input | 8 | Receive timeout event per channel |
| line_err_i | input | 32 | Four line-error event bits per channel |
| thr_empty_i | input | 8 | Holding register empty per channel |
| tsr_empty_i | input | 8 | Shift register empty per channel |
| auto485_i | input | 8 | Selects shift-register-empty as the transmit-ready source |
| modem_evt_i | input | 8 | Modem line or handshake delta event |
| xon_evt_i | input | 8 | Flow-control character detected |
| spc_evt_i | input | 8 | Special-character match |
| rx_char_i | input | 8 | A character was received |
| lsr_rd_i | input | 8 | Line status register read strobe |
| isr_rd_i | input | 8 | Interrupt status register read strobe |
| msr_rd_i | input | 8 | Modem status register read strobe |
| tmr_evt_i | input | 1 | Timer timeout event (channel 0) |
| pin_evt_i | input | 1 | Pin-change event (channel 0) |
| tmr_rd_i | input | 1 | Timer control read strobe |
| pin_rd_i | input | 1 | Pin level register read strobe |
| status_o | output | 24 | Packed 3-bit codes, channel 0 lowest |
| summary_o | output | 8 | Per-channel pending summary |
| irq_o | output | 1 | Combined interrupt |

## Verification
The embedded properties check the following on every cycle:
- a line error is followed by code 1;
- a timeout event is followed by code 1 or code 2;
- a flow-control event that coincides with an interrupt status read still leaves the channel pending;
- code 5 never appears;
- a timer event raises the combined line.

The priority ordering, each source's own clearing rule, the exposure of the next pending source, and the transmit edge selection under the auto-RS485 setting can only be shown by the bench. It runs directed sequences and a long random phase, and compares every cycle against an independent model of the requirements.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    typedef enum logic [2:0] {
        IRQ_NONE   = 3'd0,
        IRQ_RXLINE = 3'd1,
        IRQ_RXTMO  = 3'd2,
        IRQ_TXRDY  = 3'd3,
        IRQ_MODEM  = 3'd4,
        IRQ_RSVD   = 3'd5,
        IRQ_PIN    = 3'd6,
        IRQ_TIMER  = 3'd7
    } irq_code_e;

    typedef struct packed {
        logic line;
        logic tmo;
        logic tx;
        logic tx_prev;
        logic mdm;
        logic xon;
        logic spc;
        logic pin;
        logic tmr;
    } chan_state_t;
endpackage

// File: rtl/uirq_prio.sv
module uirq_prio
    import uirq_pkg::*;
(
    input  logic       dr,
    input  logic       line,
    input  logic       tmo,
    input  logic       tx,
    input  logic       mdm,
    input  logic       xon,
    input  logic       spc,
    input  logic       pin,
    input  logic       tmr,
    output logic [2:0] code_o
);
    irq_code_e code;

    always_comb begin
        if (dr || line)            code = IRQ_RXLINE;
        else if (tmo)              code = IRQ_RXTMO;
        else if (tx)               code = IRQ_TXRDY;
        else if (mdm || xon || spc) code = IRQ_MODEM;
        else if (pin)              code = IRQ_PIN;
        else if (tmr)              code = IRQ_TIMER;
        else                       code = IRQ_NONE;
    end

    assign code_o = code;
endmodule

// File: rtl/uirq_chan.sv
module uirq_chan
    import uirq_pkg::*;
#(
    parameter int LVL_W   = 7,
    parameter bit HAS_DEV = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_trig,
    input  logic             tmo_evt,
    input  logic [3:0]       line_err,
    input  logic             thr_empty,
    input  logic             tsr_empty,
    input  logic             auto485,
    input  logic             modem_evt,
    input  logic             xon_evt,
    input  logic             spc_evt,
    input  logic             rx_char,
    input  logic             lsr_rd,
    input  logic             isr_rd,
    input  logic             msr_rd,
    input  logic             tmr_evt,
    input  logic             pin_evt,
    input  logic             tmr_rd,
    input  logic             pin_rd,
    output logic [2:0]       code_o
);
    chan_state_t st_d, st_q;
    logic        tx_now;
    logic        dr;

    always_comb begin
        st_d        = st_q;
        tx_now      = auto485 ? tsr_empty : thr_empty;
        st_d.line   = (|line_err) | (st_q.line & ~lsr_rd);
        st_d.tmo    = tmo_evt | (st_q.tmo & (rx_level != '0));
        st_d.tx_prev = tx_now;
        st_d.tx     = (tx_now & ~st_q.tx_prev) | (st_q.tx & ~isr_rd);
        st_d.mdm    = modem_evt | (st_q.mdm & ~msr_rd);
        st_d.xon    = xon_evt | (st_q.xon & ~isr_rd);
        st_d.spc    = spc_evt | (st_q.spc & ~(isr_rd | rx_char));
        if (HAS_DEV) begin
            st_d.pin = pin_evt | (st_q.pin & ~pin_rd);
            st_d.tmr = tmr_evt | (st_q.tmr & ~tmr_rd);
        end else begin
            st_d.pin = 1'b0;
            st_d.tmr = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.tx_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dr = (rx_level >= rx_trig) && (rx_level != '0);

    uirq_prio u_prio (
        .dr    (dr),
        .line  (st_q.line),
        .tmo   (st_q.tmo),
        .tx    (st_q.tx),
        .mdm   (st_q.mdm),
        .xon   (st_q.xon),
        .spc   (st_q.spc),
        .pin   (st_q.pin),
        .tmr   (st_q.tmr),
        .code_o(code_o)
    );

    // R2
    line_err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|line_err) |=> (code_o == 3'd1));

    // R3
    tmo_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_evt |=> (code_o == 3'd1 || code_o == 3'd2));

    // R8
    xon_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xon_evt && isr_rd) |=> (code_o != 3'd0));

    // R6
    no_rsvd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_o != 3'd5);
endmodule

// File: rtl/uart_irq_aggregator.sv
module uart_irq_aggregator #(
    parameter int NUM_CH     = 8,
    parameter int FIFO_DEPTH = 64
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_CH*$clog2(FIFO_DEPTH+1)-1:0] rx_level_i,
    input  logic [NUM_CH*$clog2(FIFO_DEPTH+1)-1:0] rx_trig_i,
    input  logic [NUM_CH-1:0]                   rx_tmo_i,
    input  logic [NUM_CH*4-1:0]                 line_err_i,
    input  logic [NUM_CH-1:0]                   thr_empty_i,
    input  logic [NUM_CH-1:0]                   tsr_empty_i,
    input  logic [NUM_CH-1:0]                   auto485_i,
    input  logic [NUM_CH-1:0]                   modem_evt_i,
    input  logic [NUM_CH-1:0]                   xon_evt_i,
    input  logic [NUM_CH-1:0]                   spc_evt_i,
    input  logic [NUM_CH-1:0]                   rx_char_i,
    input  logic [NUM_CH-1:0]                   lsr_rd_i,
    input  logic [NUM_CH-1:0]                   isr_rd_i,
    input  logic [NUM_CH-1:0]                   msr_rd_i,
    input  logic                                tmr_evt_i,
    input  logic                                pin_evt_i,
    input  logic                                tmr_rd_i,
    input  logic                                pin_rd_i,
    output logic [NUM_CH*3-1:0]                 status_o,
    output logic [NUM_CH-1:0]                   summary_o,
    output logic                                irq_o
);
    localparam int LVL_W  = $clog2(FIFO_DEPTH + 1);
    localparam int CODE_W = 3;

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic [CODE_W-1:0] code;

        uirq_chan #(
            .LVL_W  (LVL_W),
            .HAS_DEV(n == 0)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .rx_level  (rx_level_i[n*LVL_W +: LVL_W]),
            .rx_trig   (rx_trig_i[n*LVL_W +: LVL_W]),
            .tmo_evt   (rx_tmo_i[n]),
            .line_err  (line_err_i[n*4 +: 4]),
            .thr_empty (thr_empty_i[n]),
            .tsr_empty (tsr_empty_i[n]),
            .auto485   (auto485_i[n]),
            .modem_evt (modem_evt_i[n]),
            .xon_evt   (xon_evt_i[n]),
            .spc_evt   (spc_evt_i[n]),
            .rx_char   (rx_char_i[n]),
            .lsr_rd    (lsr_rd_i[n]),
            .isr_rd    (isr_rd_i[n]),
            .msr_rd    (msr_rd_i[n]),
            .tmr_evt   ((n == 0) ? tmr_evt_i : 1'b0),
            .pin_evt   ((n == 0) ? pin_evt_i : 1'b0),
            .tmr_rd    ((n == 0) ? tmr_rd_i : 1'b0),
            .pin_rd    ((n == 0) ? pin_rd_i : 1'b0),
            .code_o    (code)
        );

        assign status_o[n*CODE_W +: CODE_W] = code;
        assign summary_o[n] = (code != '0);
    end

    assign irq_o = |summary_o;

    // R6
    timer_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_evt_i |=> irq_o);
endmodule

// File: tb/tb_uart_irq_aggregator.sv
`timescale 1ns/1ps
module tb_uart_irq_aggregator;
    localparam int NCH = 8;
    localparam int LW  = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH*LW-1:0] rx_level, rx_trig;
    logic [NCH-1:0] rx_tmo, thr_e, tsr_e, a485, mdm_e, xon_e, spc_e, rxc;
    logic [NCH-1:0] lsr_rd, isr_rd, msr_rd;
    logic [NCH*4-1:0] lerr;
    logic tmr_e, pin_e, tmr_rd, pin_rd;
    logic [NCH*3-1:0] status;
    logic [NCH-1:0] summary;
    logic irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    uart_irq_aggregator dut (
        .clk(clk), .rst_n(rst_n),
        .rx_level_i(rx_level), .rx_trig_i(rx_trig), .rx_tmo_i(rx_tmo),
        .line_err_i(lerr), .thr_empty_i(thr_e), .tsr_empty_i(tsr_e),
        .auto485_i(a485), .modem_evt_i(mdm_e), .xon_evt_i(xon_e),
        .spc_evt_i(spc_e), .rx_char_i(rxc), .lsr_rd_i(lsr_rd),
        .isr_rd_i(isr_rd), .msr_rd_i(msr_rd), .tmr_evt_i(tmr_e),
        .pin_evt_i(pin_e), .tmr_rd_i(tmr_rd), .pin_rd_i(pin_rd),
        .status_o(status), .summary_o(summary), .irq_o(irq)
    );

    // model state taken from the requirements
    bit m_line[NCH], m_tmo[NCH], m_tx[NCH], m_prev[NCH];
    bit m_mdm[NCH], m_xon[NCH], m_spc[NCH];
    bit m_pin, m_tmr;

    function automatic logic [2:0] exp_code(int ch);
        logic [LW-1:0] lv = rx_level[ch*LW +: LW];
        logic [LW-1:0] tg = rx_trig[ch*LW +: LW];
        bit dr = (lv >= tg) && (lv != 0);
        if (dr || m_line[ch]) return 3'd1;
        if (m_tmo[ch]) return 3'd2;
        if (m_tx[ch]) return 3'd3;
        if (m_mdm[ch] || m_xon[ch] || m_spc[ch]) return 3'd4;
        if (ch == 0 && m_pin) return 3'd6;
        if (ch == 0 && m_tmr) return 3'd7;
        return 3'd0;
    endfunction

    function automatic logic [NCH*3-1:0] exp_word();
        logic [NCH*3-1:0] w;
        for (int c = 0; c < NCH; c++) w[c*3 +: 3] = exp_code(c);
        return w;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_line[c] = 0; m_tmo[c] = 0; m_tx[c] = 0; m_prev[c] = 1;
            m_mdm[c] = 0; m_xon[c] = 0; m_spc[c] = 0;
        end
        m_pin = 0; m_tmr = 0;
    endtask

    task automatic model_update();
        for (int c = 0; c < NCH; c++) begin
            bit txn = a485[c] ? tsr_e[c] : thr_e[c];
            m_line[c] = (|lerr[c*4 +: 4]) | (m_line[c] & !lsr_rd[c]);
            m_tmo[c]  = rx_tmo[c] | (m_tmo[c] & (rx_level[c*LW +: LW] != 0));
            m_tx[c]   = (txn & !m_prev[c]) | (m_tx[c] & !isr_rd[c]);
            m_prev[c] = txn;
            m_mdm[c]  = mdm_e[c] | (m_mdm[c] & !msr_rd[c]);
            m_xon[c]  = xon_e[c] | (m_xon[c] & !isr_rd[c]);
            m_spc[c]  = spc_e[c] | (m_spc[c] & !(isr_rd[c] | rxc[c]));
        end
        m_pin = pin_e | (m_pin & !pin_rd);
        m_tmr = tmr_e | (m_tmr & !tmr_rd);
    endtask

    task automatic clear_inputs();
        rx_level = '0; rx_trig = {NCH{7'd8}}; rx_tmo = '0; lerr = '0;
        thr_e = '0; tsr_e = '0; a485 = '0; mdm_e = '0; xon_e = '0;
        spc_e = '0; rxc = '0; lsr_rd = '0; isr_rd = '0; msr_rd = '0;
        tmr_e = 0; pin_e = 0; tmr_rd = 0; pin_rd = 0;
    endtask

    task automatic clear_strobes();
        rx_tmo = '0; lerr = '0; mdm_e = '0; xon_e = '0; spc_e = '0; rxc = '0;
        lsr_rd = '0; isr_rd = '0; msr_rd = '0;
        tmr_e = 0; pin_e = 0; tmr_rd = 0; pin_rd = 0;
    endtask

    // inputs are set after a negedge; compare, then advance one cycle
    task automatic step(input string tag);
        logic [NCH*3-1:0] ew;
        logic [NCH-1:0] es;
        #1;
        ew = exp_word();
        for (int c = 0; c < NCH; c++) es[c] = (ew[c*3 +: 3] != 0);
        checks++;
        if (status !== ew) begin
            fails++;
            $display("FAIL %s status got %h exp %h", tag, status, ew);
        end
        checks++;
        if (summary !== es || irq !== (|es)) begin
            fails++;
            $display("FAIL %s summary/irq got %b/%b exp %b/%b", tag, summary, irq, es, |es);
        end
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_inputs();
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        step("R1");
        step("R1");

        // R2 data ready is a level condition
        rx_level[3*LW +: LW] = 7'd8; step("R2");
        rx_level[3*LW +: LW] = 7'd7; step("R2");
        rx_level[3*LW +: LW] = 7'd0; rx_trig[3*LW +: LW] = 7'd0; step("R2");
        rx_trig = {NCH{7'd8}};
        // R2 line error latch and its read clear
        lerr[1*4 + 2] = 1; step("R2");
        clear_strobes(); step("R2");
        step("R2");
        lsr_rd[1] = 1; step("R2");
        clear_strobes(); step("R2");

        // R3 timeout clears only when level reaches zero
        rx_level[2*LW +: LW] = 7'd3; rx_tmo[2] = 1; step("R3");
        clear_strobes(); step("R3");
        rx_level[2*LW +: LW] = 7'd1; step("R3");
        rx_level[2*LW +: LW] = 7'd0; step("R3");
        step("R3");

        // R4 transmit ready edge, auto485 selection
        thr_e[4] = 1; step("R4");
        step("R4");
        isr_rd[4] = 1; step("R4");
        clear_strobes(); step("R4");
        a485[4] = 1; tsr_e[4] = 0; step("R4");
        tsr_e[4] = 1; step("R4");
        step("R4");
        isr_rd[4] = 1; step("R4");
        clear_strobes(); thr_e[4] = 0; tsr_e[4] = 0; a485[4] = 0; step("R4");

        // R5 modem, flow control, special character
        mdm_e[5] = 1; xon_e[6] = 1; spc_e[7] = 1; step("R5");
        clear_strobes(); step("R5");
        isr_rd[5] = 1; msr_rd[6] = 1; step("R5");
        clear_strobes(); step("R5");
        msr_rd[5] = 1; isr_rd[6] = 1; rxc[7] = 1; step("R5");
        clear_strobes(); step("R5");

        // R6 channel 0 device sources
        tmr_e = 1; step("R6");
        clear_strobes(); step("R6");
        pin_e = 1; step("R6");
        clear_strobes(); step("R6");
        pin_rd = 1; step("R6");
        clear_strobes(); step("R6");
        tmr_rd = 1; step("R6");
        clear_strobes(); step("R6");

        // R7 priority and exposure of the next source
        rx_tmo[0] = 1; rx_level[0 +: LW] = 7'd2; mdm_e[0] = 1; lerr[0] = 1; tmr_e = 1;
        step("R7");
        clear_strobes(); step("R7");
        lsr_rd[0] = 1; step("R7");
        clear_strobes(); rx_level[0 +: LW] = 7'd0; step("R7");
        msr_rd[0] = 1; step("R7");
        clear_strobes(); tmr_rd = 1; step("R7");
        clear_strobes(); step("R7");

        // R8 set beats a same-cycle clear
        lerr[2*4 + 1] = 1; lsr_rd[2] = 1; spc_e[3] = 1; rxc[3] = 1; pin_e = 1; pin_rd = 1;
        step("R8");
        clear_strobes(); step("R8");
        lsr_rd[2] = 1; isr_rd[3] = 1; pin_rd = 1; step("R8");
        clear_strobes(); step("R8");

        // R9 random mix across all channels
        for (int i = 0; i < 4000; i++) begin
            for (int c = 0; c < NCH; c++) begin
                rx_level[c*LW +: LW] = ($urandom % 4 == 0) ? 7'($urandom % 65) : rx_level[c*LW +: LW];
                if ($urandom % 8 == 0) rx_level[c*LW +: LW] = 7'd0;
                rx_trig[c*LW +: LW] = ($urandom % 16 == 0) ? 7'(1 + $urandom % 64) : rx_trig[c*LW +: LW];
                rx_tmo[c] = ($urandom % 20 == 0);
                lerr[c*4 +: 4] = ($urandom % 24 == 0) ? 4'($urandom) : 4'd0;
                if ($urandom % 6 == 0) thr_e[c] = ~thr_e[c];
                if ($urandom % 6 == 0) tsr_e[c] = ~tsr_e[c];
                if ($urandom % 40 == 0) a485[c] = ~a485[c];
                mdm_e[c] = ($urandom % 20 == 0);
                xon_e[c] = ($urandom % 20 == 0);
                spc_e[c] = ($urandom % 20 == 0);
                rxc[c]   = ($urandom % 8 == 0);
                lsr_rd[c] = ($urandom % 6 == 0);
                isr_rd[c] = ($urandom % 6 == 0);
                msr_rd[c] = ($urandom % 6 == 0);
            end
            tmr_e = ($urandom % 20 == 0);
            pin_e = ($urandom % 20 == 0);
            tmr_rd = ($urandom % 6 == 0);
            pin_rd = ($urandom % 6 == 0);
            step("R9");
        end
        finish_run();
    end
endmodule